// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a small chip. A five-wire serial interface (test clock, mode select, serial data in, serial data out and an optional asynchronous reset) steers a sixteen-state controller. That controller selects either a 4-bit instruction path or one of three data paths and shifts it between the serial input and the serial output. The data paths are a 32-bit identification word, a single bypass flop and a boundary register that sits between the chip pins and the core. The boundary register can observe and drive the pins for board interconnect tests. It can also observe and drive the core for internal tests. A further instruction makes the block emit alternating single pulses on a dedicated output, for a self-test of the analog front end.

The serial port has no valid/ready handshake and no back-pressure. Every rising edge of the test clock moves one bit, and the test clock alone sets the pace. The pin side and the core side are plain parallel signals. Unless a test instruction takes them over, they pass straight through.

Boundary cell order: cell 0 is nearest the serial output. Cells 0 to NIN-1 are input-pin cells, matching `pin_in[0..NIN-1]` and `core_in`. Cells NIN to NIN+NOUT-1 are output-pin cells, matching `core_out` and `pin_out`. Serial data enters at the highest cell.

Top module: `tap_bscan`

## Requirements
- R1: While `trst_n` is low, the controller is held in its reset state without waiting for a clock edge. In that state `tdo_oe` is 0, `pulse_out` is 0, `test_mode` is 0, `pin_out` equals `core_out`, `core_in` equals `pin_in`, and the active instruction is IDCODE (4'b0011).
- R2: Five consecutive rising edges with `tms` high bring the controller to its reset state from any state, and the active instruction becomes IDCODE.
- R3: The instruction shift stage loads 4'b0001 in Capture-IR, and that value is the first thing shifted out (LSB first). A shifted opcode becomes active only on the falling edge in Update-IR. The opcodes are 0000 for EXTEST, 0001 for INTEST, 0010 for SAMPLE/PRELOAD, 0011 for IDCODE, 0100 for PULSE and 1111 for BYPASS.
- R4: Under IDCODE the data path is a 32-bit word, shifted out LSB first. It is 32'h1002A083: version 4'b0001 in bits 31..28, device code 16'h002A in bits 27..12, maker code 11'b00001000001 in bits 11..1, and bit 0 fixed at 1.
- R5: BYPASS, PULSE and every unassigned opcode (for example 0111) select a one-bit data path. That path captures 0, and it delays each serial input bit by exactly one shift.
- R6: Under EXTEST, Capture-DR loads the input-pin cells from `pin_in`. The falling edge in Update-DR drives the output-pin cells onto `pin_out`. `test_mode` is 1.
- R7: Under INTEST, Capture-DR loads the output-pin cells from `core_out`. The falling edge in Update-DR drives the input-pin cells onto `core_in`. `test_mode` is 1.
- R8: Under SAMPLE/PRELOAD, Capture-DR loads both the input-pin cells (from `pin_in`) and the output-pin cells (from `core_out`). The pins and the core stay on the functional path. A vector preloaded this way appears on `pin_out` as soon as EXTEST becomes active.
- R9: `tdo` changes only on falling edges of `tck`. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.
- R10: Under PULSE, each rising edge spent in Run-Test/Idle toggles `pulse_out`, so the output reads 1, 0, 1, 0 from the first such edge. Otherwise `pulse_out` is 0, and it is never high under any other instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (tie high if unused) |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | NIN | Levels on the chip's input pins |
| core_out | input | NOUT | Core-side values for the output pins |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; 0 means high-impedance |
| pin_out | output | NOUT | Values driven to the output pins |
| core_in | output | NIN | Values fed to the core's inputs |
| test_mode | output | 1 | 1 while EXTEST or INTEST is active |
| pulse_out | output | 1 | Self-test pulse output |

## Verification
A wrong controller state shows up within one falling edge as a misplaced `tdo_oe`. It also shows up as a captured word that is shifted by one or more bit positions at the serial output. A wrong instruction shows up at the next data scan as a path length other than 1, 32 or NIN+NOUT bits. It also shows up at once through `test_mode` and the pin multiplexers. A corrupted boundary or update cell appears on `pin_out` or `core_in` on the falling edge of the next Update-DR. It can also be read back serially on the following scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
    ST_UP_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  localparam int unsigned OP_W = 4;
  localparam logic [OP_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [OP_W-1:0] OP_INTEST = 4'b0001;
  localparam logic [OP_W-1:0] OP_SAMPLE = 4'b0010;
  localparam logic [OP_W-1:0] OP_IDCODE = 4'b0011;
  localparam logic [OP_W-1:0] OP_PULSE  = 4'b0100;
  localparam logic [OP_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [OP_W-1:0] IR_CAPTURE = 4'b0001;

  typedef struct packed {
    logic ext;
    logic intst;
    logic sample;
    logic idsel;
    logic pulse;
  } instr_t;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  return m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: return m ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  return m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: return m ? ST_UP_IR  : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic instr_t tap_decode(input logic [OP_W-1:0] op);
    instr_t d;
    d = '0;
    case (op)
      OP_EXTEST: d.ext    = 1'b1;
      OP_INTEST: d.intst  = 1'b1;
      OP_SAMPLE: d.sample = 1'b1;
      OP_IDCODE: d.idsel  = 1'b1;
      OP_PULSE:  d.pulse  = 1'b1;
      default:   d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [OP_W-1:0] ir_sr,
  output logic [OP_W-1:0] ir_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sr <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[OP_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                ir_q <= OP_IDCODE;
    else if (state == ST_RESET) ir_q <= OP_IDCODE;
    else if (state == ST_UP_IR) ir_q <= ir_sr;
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int unsigned NIN    = 4,
  parameter int unsigned NOUT   = 4,
  parameter logic [31:0] IDWORD = 32'h1002A083,
  localparam int unsigned NB    = NIN + NOUT
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  instr_t          dec,
  input  logic            tdi,
  input  logic [NIN-1:0]  pin_in,
  input  logic [NOUT-1:0] core_out,
  output logic            dr_lsb,
  output logic [NB-1:0]   upd
);
  logic        bscan_sel;
  logic        byp_q;
  logic [31:0] id_sr;
  logic [NB-1:0] bsr;
  logic [NB-1:0] shin;

  assign bscan_sel = dec.ext | dec.intst | dec.sample;
  assign shin      = {tdi, bsr[NB-1:1]};

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sr <= IDWORD;
    end else begin
      if (state == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state == ST_SH_DR) byp_q <= tdi;
      if (dec.idsel && state == ST_CAP_DR)     id_sr <= IDWORD;
      else if (dec.idsel && state == ST_SH_DR) id_sr <= {tdi, id_sr[31:1]};
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_cell
    logic cap_en, cap_val, cell_q, upd_q;
    if (g < NIN) begin : g_in
      assign cap_en  = dec.ext | dec.sample;
      assign cap_val = pin_in[g];
    end else begin : g_out
      assign cap_en  = dec.intst | dec.sample;
      assign cap_val = core_out[g-NIN];
    end

    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                                      cell_q <= 1'b0;
      else if (bscan_sel && state == ST_CAP_DR && cap_en) cell_q <= cap_val;
      else if (bscan_sel && state == ST_SH_DR)          cell_q <= shin[g];
    end

    always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                               upd_q <= 1'b0;
      else if (bscan_sel && state == ST_UP_DR)   upd_q <= cell_q;
    end

    assign bsr[g] = cell_q;
    assign upd[g] = upd_q;
  end

  always_comb begin
    if (dec.idsel)      dr_lsb = id_sr[0];
    else if (bscan_sel) dr_lsb = bsr[0];
    else                dr_lsb = byp_q;
  end
endmodule

// File: rtl/tap_bscan.sv
module tap_bscan
  import tap_pkg::*;
#(
  parameter int unsigned NIN       = 4,
  parameter int unsigned NOUT      = 4,
  parameter logic [3:0]  ID_VER    = 4'b0001,
  parameter logic [15:0] ID_PART   = 16'h002A,
  parameter logic [10:0] ID_MAKER  = 11'b00001000001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic [NIN-1:0]  pin_in,
  input  logic [NOUT-1:0] core_out,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [NOUT-1:0] pin_out,
  output logic [NIN-1:0]  core_in,
  output logic            test_mode,
  output logic            pulse_out
);
  localparam int unsigned NB     = NIN + NOUT;
  localparam logic [31:0] IDWORD = {ID_VER, ID_PART, ID_MAKER, 1'b1};

  tap_state_e      state;
  logic [OP_W-1:0] ir_sr;
  logic [OP_W-1:0] ir_q;
  instr_t          dec;
  logic            dr_lsb;
  logic [NB-1:0]   upd;
  logic            tdo_q, oe_q, pulse_q;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi), .ir_sr(ir_sr), .ir_q(ir_q)
  );

  assign dec = tap_decode(ir_q);

  tap_dr #(.NIN(NIN), .NOUT(NOUT), .IDWORD(IDWORD)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .dec(dec), .tdi(tdi),
    .pin_in(pin_in), .core_out(core_out), .dr_lsb(dr_lsb), .upd(upd)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
      tdo_q <= (state == ST_SH_IR) ? ir_sr[0] : dr_lsb;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                              pulse_q <= 1'b0;
    else if (dec.pulse && state == ST_IDLE)   pulse_q <= ~pulse_q;
    else                                      pulse_q <= 1'b0;
  end

  assign tdo       = tdo_q;
  assign tdo_oe    = oe_q;
  assign pulse_out = pulse_q;
  assign test_mode = dec.ext | dec.intst;
  assign pin_out   = dec.ext   ? upd[NB-1:NIN] : core_out;
  assign core_in   = dec.intst ? upd[NIN-1:0]  : pin_in;
endmodule

// File: rtl/tap_bscan_chk.sv
module tap_bscan_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [OP_W-1:0] ir_q,
  input logic [OP_W-1:0] ir_sr,
  input logic            tdo_oe,
  input logic            pulse_out
);
  logic [2:0] ones;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones <= '0;
    else if (!tms)        ones <= '0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (state == ST_RESET));

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  a_r3_ir_update_only: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_q) |-> (state == ST_UP_IR || state == ST_RESET));

  a_r9_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

  a_r10_pulse_instr: assert property (@(posedge tck) disable iff (!trst_n)
    pulse_out |-> (ir_q == OP_PULSE));
endmodule

bind tap_bscan tap_bscan_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_q(ir_q),
  .ir_sr(ir_sr), .tdo_oe(tdo_oe), .pulse_out(pulse_out)
);

// File: tb/tb_tap_bscan.sv
`timescale 1ns/1ps
module tb_tap_bscan;
  localparam int NIN = 4;
  localparam int NOUT = 4;
  localparam logic [31:0] ID = 32'h1002A083;
  localparam int NTAB = 6;
  // {pin_in[3:0], boundary vector[7:0]}
  localparam logic [11:0] EXT_TAB [NTAB] = '{12'hA5C, 12'h0FF, 12'hF00, 12'h381, 12'hC7E, 12'h619};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [NIN-1:0] pin_in = '0;
  logic [NOUT-1:0] core_out = '0;
  logic tdo, tdo_oe, test_mode, pulse_out;
  logic [NOUT-1:0] pin_out;
  logic [NIN-1:0] core_in;
  int tests = 0, fails = 0;
  logic [31:0] dout;
  logic [3:0] icap;

  always #4 tck = ~tck;

  tap_bscan #(.NIN(NIN), .NOUT(NOUT)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in), .core_out(core_out),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out), .core_in(core_in),
    .test_mode(test_mode), .pulse_out(pulse_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] q);
    q = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      q[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] q);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      q[i] = tdo;
      step(i == 3, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    pin_in = 4'h3; core_out = 4'hA;
    #21;
    chk("R1 oe in reset", {31'd0, tdo_oe}, 32'd0);
    chk("R1 pins functional", {28'd0, pin_out}, 32'hA);
    chk("R1 core functional", {28'd0, core_in}, 32'h3);
    chk("R1 mode", {31'd0, test_mode}, 32'd0);
    trst_n = 1'b1;
    @(negedge tck); #2;
    step(0, 0);
    chk("R9 oe idle", {31'd0, tdo_oe}, 32'd0);
    scan_dr(32, 32'h0, dout);
    chk("R4 idcode word", dout, ID);

    // R3 capture pattern; R6 EXTEST table
    scan_ir(4'b0000, icap);
    chk("R3 ir capture", {28'd0, icap}, 32'h1);
    chk("R6 mode", {31'd0, test_mode}, 32'd1);
    for (int k = 0; k < NTAB; k++) begin
      pin_in = EXT_TAB[k][11:8];
      scan_dr(8, {24'd0, EXT_TAB[k][7:0]}, dout);
      chk("R6 captured pins", {28'd0, dout[3:0]}, {28'd0, EXT_TAB[k][11:8]});
      chk("R6 driven pins", {28'd0, pin_out}, {28'd0, EXT_TAB[k][7:4]});
      chk("R6 core path", {28'd0, core_in}, {28'd0, pin_in});
    end

    // R7 INTEST
    scan_ir(4'b0001, icap);
    core_out = 4'h5; pin_in = 4'hE;
    scan_dr(8, 32'h0C, dout);
    chk("R7 captured core", {28'd0, dout[7:4]}, 32'h5);
    chk("R7 core driven", {28'd0, core_in}, 32'hC);
    chk("R7 mode", {31'd0, test_mode}, 32'd1);

    // R8 SAMPLE/PRELOAD
    scan_ir(4'b0010, icap);
    pin_in = 4'h9; core_out = 4'h6;
    scan_dr(8, 32'hB2, dout);
    chk("R8 sample pins", {28'd0, dout[3:0]}, 32'h9);
    chk("R8 sample core", {28'd0, dout[7:4]}, 32'h6);
    chk("R8 pins untouched", {28'd0, pin_out}, 32'h6);
    chk("R8 core untouched", {28'd0, core_in}, 32'h9);
    chk("R8 mode", {31'd0, test_mode}, 32'd0);
    scan_ir(4'b0000, icap);
    chk("R8 preload drives", {28'd0, pin_out}, 32'hB);

    // R5 unassigned opcode acts as one-bit path
    scan_ir(4'b0111, icap);
    scan_dr(8, 32'hA5, dout);
    chk("R5 unassigned bypass", {24'd0, dout[7:0]}, 32'h4A);
    chk("R5 pins functional", {28'd0, pin_out}, 32'h6);

    // R9 TDO timing with BYPASS
    scan_ir(4'b1111, icap);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R5 bypass captures 0", {31'd0, tdo}, 32'd0);
    chk("R9 oe shift", {31'd0, tdo_oe}, 32'd1);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R9 stable at rise", {31'd0, tdo}, 32'd0);
    @(negedge tck); #2;
    chk("R9 change at fall", {31'd0, tdo}, 32'd1);
    step(1, 0);
    chk("R9 oe off exit", {31'd0, tdo_oe}, 32'd0);
    step(1, 0); step(0, 0);

    // R10 pulse
    scan_ir(4'b0100, icap);
    chk("R10 no pulse before idle", {31'd0, pulse_out}, 32'd0);
    step(0, 0); chk("R10 pulse 1", {31'd0, pulse_out}, 32'd1);
    step(0, 0); chk("R10 pulse 2", {31'd0, pulse_out}, 32'd0);
    step(0, 0); chk("R10 pulse 3", {31'd0, pulse_out}, 32'd1);
    step(0, 0); chk("R10 pulse 4", {31'd0, pulse_out}, 32'd0);
    step(1, 0); step(1, 0);
    chk("R10 pulse stops", {31'd0, pulse_out}, 32'd0);

    // R2 five TMS ones from Shift-DR
    step(0, 0); step(0, 0);
    scan_ir(4'b1111, icap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R2 oe after reset walk", {31'd0, tdo_oe}, 32'd0);
    step(0, 0);
    scan_dr(32, 32'h0, dout);
    chk("R2 idcode restored", dout, ID);

    // R1 asynchronous reset from Shift-DR under EXTEST
    scan_ir(4'b0000, icap);
    core_out = 4'h1;
    step(1, 0); step(0, 0); step(0, 0);
    #1 trst_n = 1'b0;
    #1;
    chk("R1 async oe", {31'd0, tdo_oe}, 32'd0);
    chk("R1 async pins", {28'd0, pin_out}, 32'h1);
    chk("R1 async mode", {31'd0, test_mode}, 32'd0);
    trst_n = 1'b1;
    @(negedge tck); #2;
    step(0, 0);
    scan_dr(32, 32'h0, dout);
    chk("R1 idcode after trst", dout, ID);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule